// File: doc/BRIEF.md
# Power Management Timer

This block is a free-running up-counter for power management. Its rate is fixed by a tick input, a one-cycle enable pulse in the system clock domain that arrives at 3.579545 MHz. The counter is `CNT_W` bits wide, with a default of 24. A control bit turns the timer on or off. Whenever the counter's top bit changes value, in either direction, a status flag sets. Software clears the flag by writing a one to it. When the interrupt-enable bit is set, the flag drives a request line to the system control interrupt logic.

Software reads the count through three byte-wide registers on a small register port. A read of the low byte returns the live low byte. The same read captures the upper two bytes into a snapshot, so a low/mid/high read sequence always returns one coherent value. The timer comes out of reset running, so no software setup is needed after power-up.

Top module: `pmtmr`

## Requirements
- R1: On each clock cycle where `tickEn` is 1 and timer-on is 1, the count increases by exactly one. It wraps from all-ones (0xFFFFFF at the default width) to 0.
- R2: When `tickEn` is 0 or timer-on is 0, the count holds its value and the status flag does not set.
- R3: The status flag sets on every count step that changes the counter's top bit. This covers both 0-to-1 and 1-to-0.
- R4: `sciReq` is 1 exactly when the status flag is 1 and the interrupt-enable bit is 1. Both values are taken from the same cycle.
- R5: Writing address 3 with data bit 0 at 1 clears the status flag. Writing it with bit 0 at 0 has no effect. If a top-bit change happens in the same cycle as the clear, the flag stays set.
- R6: A read strobe at address 0 returns count bits 7:0 in the same cycle. On that edge it latches count bits 23:8 into a snapshot. Address 1 returns snapshot bits 15:8 and address 2 returns snapshot bits 23:16. Count bits above `CNT_W` read as 0.
- R7: After reset the count is 0, the status flag is 0, interrupt-enable is 0 and timer-on is 1. The timer advances on ticks with no register write.
- R8: Address 3 bit 0 is the status flag, address 4 bit 0 is interrupt-enable, and address 5 bit 0 is timer-on. All other bits and addresses 6 and 7 read 0. Writes to addresses 0, 1 and 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle pulse at the timer rate |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (matters at address 0) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for `regAddr`, combinational |
| sciReq | output | 1 | Interrupt request to system control logic |

## Verification
A counter that slips or double-steps shows at the low byte on the next read. A missed or spurious top-bit event shows in the flag and in `sciReq` on the cycle after the step that should have caused it. The bench uses a reduced counter width so that both directions of the top-bit change and the wrap are reached within a few thousand ticks. A snapshot taken from the wrong cycle shows at the first mid-byte read after a low-byte read that lands on a carry into bit 8.

// File: rtl/pmtmr_pkg.sv
package pmtmr_pkg;

  localparam int REG_BYTES = 3;
  localparam int REG_W     = 8 * REG_BYTES;

  typedef enum logic [2:0] {
    ADDR_CNT_LO  = 3'd0,
    ADDR_CNT_MID = 3'd1,
    ADDR_CNT_HI  = 3'd2,
    ADDR_STATUS  = 3'd3,
    ADDR_IRQ_EN  = 3'd4,
    ADDR_CTRL    = 3'd5
  } regAddr_e;

  typedef struct packed {
    logic advance;
    logic latchSnap;
    logic clrStatus;
  } strobes_t;

endpackage

// File: rtl/pmtmr_dp.sv
module pmtmr_dp
  import pmtmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strobes,
  output logic [CNT_W-1:0]     count,
  output logic [REG_W-1:0]     countWide,
  output logic [REG_W-9:0]     snapWide,
  output logic                 statusFlag
);

  localparam int TOP = CNT_W - 1;

  logic [CNT_W-1:0] countNext;
  logic             topChange;

  assign countNext = count + CNT_W'(1);
  assign topChange = strobes.advance && (countNext[TOP] != count[TOP]);

  generate
    if (CNT_W < REG_W) begin : g_pad
      assign countWide = {{(REG_W - CNT_W){1'b0}}, count};
    end else begin : g_full
      assign countWide = count;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= '0;
      snapWide   <= '0;
      statusFlag <= 1'b0;
    end else begin
      if (strobes.advance)   count    <= countNext;
      if (strobes.latchSnap) snapWide <= countWide[REG_W-1:8];
      statusFlag <= topChange || (statusFlag && !strobes.clrStatus);
    end
  end

endmodule

// File: rtl/pmtmr_ctrl.sv
module pmtmr_ctrl
  import pmtmr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic [2:0]           regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [7:0]           regWdata,
  input  logic [REG_W-1:0]     countWide,
  input  logic [REG_W-9:0]     snapWide,
  input  logic                 statusFlag,
  output strobes_t             strobes,
  output logic                 timerOn,
  output logic                 timerEnable,
  output logic [7:0]           regRdata
);

  regAddr_e addr;
  assign addr = regAddr_e'(regAddr);

  always_comb begin
    strobes.advance   = tickEn && timerOn;
    strobes.latchSnap = regRd && (addr == ADDR_CNT_LO);
    strobes.clrStatus = regWr && (addr == ADDR_STATUS) && regWdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerOn     <= 1'b1;
      timerEnable <= 1'b0;
    end else if (regWr) begin
      if (addr == ADDR_CTRL)   timerOn     <= regWdata[0];
      if (addr == ADDR_IRQ_EN) timerEnable <= regWdata[0];
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CNT_LO:  regRdata = countWide[7:0];
      ADDR_CNT_MID: regRdata = snapWide[7:0];
      ADDR_CNT_HI:  regRdata = snapWide[15:8];
      ADDR_STATUS:  regRdata = {7'b0, statusFlag};
      ADDR_IRQ_EN:  regRdata = {7'b0, timerEnable};
      ADDR_CTRL:    regRdata = {7'b0, timerOn};
      default:      regRdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/pmtmr.sv
module pmtmr
  import pmtmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [2:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       sciReq
);

  strobes_t          strobes;
  logic [CNT_W-1:0]  count;
  logic [REG_W-1:0]  countWide;
  logic [REG_W-9:0]  snapWide;
  logic              statusFlag;
  logic              timerOn;
  logic              timerEnable;

  pmtmr_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .regAddr     (regAddr),
    .regWr       (regWr),
    .regRd       (regRd),
    .regWdata    (regWdata),
    .countWide   (countWide),
    .snapWide    (snapWide),
    .statusFlag  (statusFlag),
    .strobes     (strobes),
    .timerOn     (timerOn),
    .timerEnable (timerEnable),
    .regRdata    (regRdata)
  );

  pmtmr_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .count      (count),
    .countWide  (countWide),
    .snapWide   (snapWide),
    .statusFlag (statusFlag)
  );

  assign sciReq = statusFlag && timerEnable;

endmodule

// File: rtl/pmtmr_checker.sv
module pmtmr_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic [2:0]       regAddr,
  input logic             regWr,
  input logic             regRd,
  input logic [7:0]       regWdata,
  input logic [CNT_W-1:0] count,
  input logic [15:0]      snapWide,
  input logic             statusFlag,
  input logic             timerOn
);

  logic stepping;
  logic topEdge;
  logic clearWr;

  assign stepping = tickEn && timerOn;
  assign topEdge  = stepping && (&count[CNT_W-2:0]);
  assign clearWr  = regWr && (regAddr == 3'd3) && regWdata[0];

  p_advance_r1: assert property (@(posedge clk) disable iff (!rstN)
    stepping |=> count == ($past(count) + CNT_W'(1)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stepping |=> $stable(count));

  p_no_event_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stepping && !statusFlag) |=> !statusFlag);

  p_top_change_r3: assert property (@(posedge clk) disable iff (!rstN)
    topEdge |=> statusFlag);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clearWr && !topEdge) |=> !statusFlag);

  p_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusFlag && !clearWr) |=> statusFlag);

  p_snapshot_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 3'd0) |=> snapWide == 16'($past(count) >> 8));

endmodule

bind pmtmr pmtmr_checker #(.CNT_W(CNT_W)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .tickEn     (tickEn),
  .regAddr    (regAddr),
  .regWr      (regWr),
  .regRd      (regRd),
  .regWdata   (regWdata),
  .count      (count),
  .snapWide   (snapWide),
  .statusFlag (statusFlag),
  .timerOn    (timerOn)
);

// File: tb/pmtmr_bench.sv
module pmtmr_bench;

  localparam int W    = 12;
  localparam int MASK = (1 << W) - 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       sciReq;

  always #2 clk = ~clk;

  pmtmr #(.CNT_W(W)) u_pmtmr (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regRd    (regRd),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .sciReq   (sciReq)
  );

  typedef struct {
    logic       chkRd;
    logic       chkSci;
    logic [7:0] expRd;
    logic       expSci;
    string      tag;
  } item_t;

  item_t queue_q[$];
  event  cmpEv;
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  int mCnt  = 0;
  int mSnap = 0;
  bit mFlag = 0;
  bit mEn   = 0;
  bit mOn   = 1;

  initial begin
    forever begin
      @(cmpEv);
      #1;
      if (queue_q.size() > 0) begin
        item_t it;
        it = queue_q.pop_front();
        if (it.chkRd) begin
          checks++;
          if (regRdata !== it.expRd) begin
            fails++;
            $display("FAIL %s: regRdata actual %02h expected %02h", it.tag, regRdata, it.expRd);
          end
        end
        if (it.chkSci) begin
          checks++;
          if (sciReq !== it.expSci) begin
            fails++;
            $display("FAIL %s: sciReq actual %0b expected %0b", it.tag, sciReq, it.expSci);
          end
        end
      end
    end
  end

  function automatic logic [7:0] expRead(input logic [2:0] a);
    case (a)
      3'd0:    return 8'(mCnt);
      3'd1:    return 8'(mSnap >> 8);
      3'd2:    return 8'(mSnap >> 16);
      3'd3:    return {7'b0, mFlag};
      3'd4:    return {7'b0, mEn};
      3'd5:    return {7'b0, mOn};
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input logic tk, input logic wr, input logic rd, input logic [2:0] a,
                      input logic [7:0] wd, input logic chkRd, input logic chkSci, input string tag);
    item_t it;
    int nxt;
    bit adv, setEv, clr;
    @(negedge clk);
    tickEn = tk; regWr = wr; regRd = rd; regAddr = a; regWdata = wd;
    it.chkRd = chkRd; it.chkSci = chkSci; it.tag = tag;
    it.expRd = expRead(a);
    it.expSci = mFlag && mEn;
    queue_q.push_back(it);
    ->cmpEv;
    adv   = tk && mOn;
    nxt   = (mCnt + 1) & MASK;
    setEv = adv && (((nxt >> (W - 1)) & 1) != ((mCnt >> (W - 1)) & 1));
    clr   = wr && a == 3'd3 && wd[0];
    mFlag = setEv || (mFlag && !clr);
    if (rd && a == 3'd0) mSnap = mCnt & ~8'hFF;
    if (wr && a == 3'd4) mEn = wd[0];
    if (wr && a == 3'd5) mOn = wd[0];
    if (adv) mCnt = nxt;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 3'd0, 8'h00, 0, 0, "");
  endtask

  task automatic runTo(input int target);
    while (mCnt != target) step(1, 0, 0, 3'd0, 8'h00, 0, 0, "");
  endtask

  task automatic rdChk(input logic [2:0] a, input string tag);
    step(0, 0, 1, a, 8'h00, 1, 1, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(0, 1, 0, a, d, 0, 0, "");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: run actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    rdChk(3'd5, "R7 timer-on after reset");
    rdChk(3'd4, "R7 enable after reset");
    rdChk(3'd3, "R7 flag after reset");
    rdChk(3'd0, "R7 count after reset");

    tick(5);
    rdChk(3'd0, "R1 count after five ticks");
    step(0, 0, 0, 3'd0, 8'h00, 0, 0, "");
    step(0, 0, 0, 3'd0, 8'h00, 0, 0, "");
    rdChk(3'd0, "R2 hold without tick");

    wr(3'd5, 8'h00);
    tick(10);
    rdChk(3'd0, "R2 hold with timer off");
    rdChk(3'd5, "R8 timer-on readback");
    wr(3'd5, 8'h01);

    runTo(8'hFF);
    step(1, 0, 1, 3'd0, 8'h00, 1, 0, "R6 low byte live at carry");
    tick(1);
    rdChk(3'd1, "R6 mid byte from snapshot");
    rdChk(3'd2, "R6 high byte from snapshot");
    rdChk(3'd0, "R6 low byte relatch");
    rdChk(3'd1, "R6 mid byte after relatch");

    runTo(MASK >> 1);
    rdChk(3'd3, "R3 flag before top change");
    tick(1);
    rdChk(3'd3, "R3 flag on top rise and R4 sci masked");
    wr(3'd4, 8'h01);
    rdChk(3'd4, "R4 sci with enable");
    wr(3'd3, 8'h00);
    rdChk(3'd3, "R5 write zero keeps flag");
    wr(3'd3, 8'h01);
    rdChk(3'd3, "R5 write one clears flag");

    runTo(MASK);
    tick(1);
    rdChk(3'd0, "R1 wrap to zero");
    rdChk(3'd3, "R3 flag on top fall");
    wr(3'd3, 8'h01);

    runTo(MASK >> 1);
    wr(3'd5, 8'h00);
    tick(3);
    rdChk(3'd3, "R2 no event with timer off");
    wr(3'd5, 8'h01);
    step(1, 1, 0, 3'd3, 8'h01, 0, 0, "");
    rdChk(3'd3, "R5 set wins over clear");

    wr(3'd0, 8'hAA);
    rdChk(3'd0, "R8 count write ignored");
    rdChk(3'd6, "R8 unused address reads zero");
    wr(3'd4, 8'hFE);
    rdChk(3'd4, "R8 enable uses bit 0 only");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule